// File: doc/BRIEF.md
# Transmit Queue Host Request Controller

This block sits between a host bus and a MAC transmit serializer. The host writes frame bytes into a byte-wide queue. Each write carries an end-of-frame marker for the last byte of a frame. The serializer drains the queue through a valid/ready byte stream that is tagged with start-of-frame and end-of-frame. The block raises a write request to the host once the queue has room for the number of write cycles selected by a two-bit threshold. The request follows the same rule whether or not burst mode is selected.

The block also holds the transmit enable. While transmit is off, no queued byte reaches the MAC side and host writes are refused. A sticky error flag records each refused write. Clearing the enable flushes the queue. If a frame has already started on the MAC side when the enable is cleared, the block closes that frame with one extra filler byte. That byte carries end-of-frame and a force-bad-CRC flag, so the receiver sees a frame-check violation. A hardware reset or a software reset returns the configuration, the queue and the error flag to zero.

Top module: `txq_host_ctrl`

## Requirements
- R1: `host_req` is high exactly when transmit is enabled and the free space (64 minus stored bytes) is at least 8 << `cfg_thr`, so threshold codes 0, 1, 2 and 3 need 8, 16, 32 and 64 free bytes.
- R2: The burst-mode bit has no effect on `host_req`.
- R3: While transmit is disabled and no abort byte is pending, `mac_valid` stays low.
- R4: Bytes leave in the order written. `mac_sof` marks the first byte of each frame, and `mac_eof` marks the byte written with `host_eof` set.
- R5: A configuration write with `cfg_tx_en`=0 empties the queue. After re-enabling, all 64 bytes are free and the next byte sent carries `mac_sof`.
- R6: When transmit is disabled after at least one byte of a frame has been transferred and before its end byte has been transferred, exactly one extra transfer follows. It has data 0x00, `mac_eof`=1 and `mac_bad_crc`=1. Disabling between frames adds no transfer.
- R7: `rst_n` low, or `sw_rst` high at a clock edge, clears the enable, the threshold, the burst bit, the error flag, the queue and the frame state.
- R8: `mac_bad_crc` is high only together with `mac_valid` and `mac_eof`. It holds until `mac_ready` accepts it and then drops, so it marks exactly one transfer.
- R9: A host write while transmit is disabled stores nothing and sets `wr_err`, which stays high until a reset.
- R10: A host write while the queue holds 64 bytes is dropped and does not set `wr_err`.
- R11: While `mac_valid` is high and `mac_ready` is low, the offered byte and its flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tx_en | input | 1 | Transmit enable value written |
| cfg_thr | input | 2 | Free-space threshold code written |
| cfg_burst | input | 1 | Burst-mode bit written |
| host_wr | input | 1 | Host byte write strobe |
| host_data | input | 8 | Host byte |
| host_eof | input | 1 | Marks the last byte of a frame |
| host_req | output | 1 | Request for host writes |
| wr_err | output | 1 | Sticky flag for refused writes |
| mac_ready | input | 1 | Serializer accepts the offered byte |
| mac_valid | output | 1 | A byte is offered |
| mac_data | output | 8 | Offered byte |
| mac_sof | output | 1 | First byte of a frame |
| mac_eof | output | 1 | Last byte of a frame |
| mac_bad_crc | output | 1 | Force a corrupted frame check on this frame |

## Verification
The assertions are checked on every cycle. They cover these rules: the queue never overflows or underflows, a disable always empties it, the MAC side stays silent while transmit is off, the offered byte is held while the serializer stalls, the forced-bad-CRC byte is framed as an end byte and clears once accepted, the error flag is sticky, and an accepted write raises the occupancy by one. Some behaviour only the directed scenarios can show. These are the exact threshold boundaries for each code, the invariance under burst mode, byte order and frame marking over a full queue, dropping of writes to a full queue, the single filler transfer after a mid-frame disable and its absence after a disable between frames, and the effect of the software reset.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } txq_entry_t;
endpackage

// File: rtl/txq_cfg.sv
module txq_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       cfg_wr,
    input  logic       cfg_tx_en,
    input  logic [1:0] cfg_thr,
    input  logic       cfg_burst,
    input  logic       host_wr,
    output logic       en_q,
    output logic [1:0] thr_q,
    output logic       burst_q,
    output logic       err_q,
    output logic       dis_evt
);
    typedef struct packed {
        logic       en;
        logic [1:0] thr;
        logic       burst;
        logic       err;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr && !st_q.en) begin
            st_d.err = 1'b1;
        end
        if (cfg_wr) begin
            st_d.en    = cfg_tx_en;
            st_d.thr   = cfg_thr;
            st_d.burst = cfg_burst;
        end
        if (sw_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q    = st_q.en;
    assign thr_q   = st_q.thr;
    assign burst_q = st_q.burst;
    assign err_q   = st_q.err;
    assign dis_evt = cfg_wr && !cfg_tx_en && !sw_rst;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !sw_rst) |=> err_q); // R9
    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!en_q && thr_q == 2'd0 && !burst_q && !err_q)); // R7
endmodule

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           push,
    input  txq_entry_t                     push_ent,
    input  logic                           pop,
    output txq_entry_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t       st_d, st_q;
    txq_entry_t mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            if (pop)  st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[st_q.wr_ptr] <= push_ent;
    end

    assign head  = mem_q[st_q.rd_ptr];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R5
endmodule

// File: rtl/txq_tx_seq.sv
module txq_tx_seq
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              en_q,
    input  logic              dis_evt,
    input  logic              empty,
    input  txq_entry_t        head,
    input  logic              mac_ready,
    output logic              pop,
    output logic              mac_valid,
    output logic [BYTE_W-1:0] mac_data,
    output logic              mac_sof,
    output logic              mac_eof,
    output logic              mac_bad_crc
);
    typedef struct packed {
        logic in_frame;
        logic abort_pend;
    } seq_t;

    seq_t st_d, st_q;
    logic fifo_offer;
    logic frame_open;

    assign fifo_offer = en_q && !empty && !st_q.abort_pend;
    assign pop        = fifo_offer && mac_ready;

    always_comb begin
        st_d       = st_q;
        frame_open = pop ? !head.last : st_q.in_frame;
        st_d.in_frame = frame_open;
        if (st_q.abort_pend && mac_ready) begin
            st_d.abort_pend = 1'b0;
        end
        if (dis_evt) begin
            st_d.abort_pend = st_d.abort_pend || frame_open;
            st_d.in_frame   = 1'b0;
        end
        if (sw_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mac_valid   = st_q.abort_pend || fifo_offer;
    assign mac_data    = fifo_offer ? head.data : '0;
    assign mac_sof     = fifo_offer && !st_q.in_frame;
    assign mac_eof     = st_q.abort_pend || (fifo_offer && head.last);
    assign mac_bad_crc = st_q.abort_pend;

    AST_BADCRC_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        mac_bad_crc |-> (mac_valid && mac_eof && !mac_sof)); // R8
    AST_BADCRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_bad_crc && !mac_ready && !sw_rst) |=> mac_bad_crc); // R8
    AST_BADCRC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_bad_crc && mac_ready) |=> !mac_bad_crc); // R8
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !mac_bad_crc) |-> !mac_valid); // R3
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !mac_ready && !sw_rst && !dis_evt)
        |=> (mac_valid && $stable(mac_data) && $stable(mac_eof) && $stable(mac_sof))); // R11
endmodule

// File: rtl/txq_host_ctrl.sv
module txq_host_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int THR_BASE  = 8,
    parameter int THR_CODES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cfg_wr,
    input  logic              cfg_tx_en,
    input  logic [1:0]        cfg_thr,
    input  logic              cfg_burst,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              host_eof,
    output logic              host_req,
    output logic              wr_err,
    input  logic              mac_ready,
    output logic              mac_valid,
    output logic [BYTE_W-1:0] mac_data,
    output logic              mac_sof,
    output logic              mac_eof,
    output logic              mac_bad_crc
);
    localparam int CW = $clog2(DEPTH+1);

    logic          en_q, burst_q, dis_evt, flush, push, pop, empty, full;
    logic [1:0]    thr_q;
    logic [CW-1:0] count, free_sp;
    txq_entry_t    push_ent, head;
    logic [CW-1:0] need_tbl [THR_CODES];

    for (genvar g = 0; g < THR_CODES; g++) begin : g_need
        assign need_tbl[g] = CW'(THR_BASE << g);
    end

    txq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .cfg_wr   (cfg_wr),
        .cfg_tx_en(cfg_tx_en),
        .cfg_thr  (cfg_thr),
        .cfg_burst(cfg_burst),
        .host_wr  (host_wr),
        .en_q     (en_q),
        .thr_q    (thr_q),
        .burst_q  (burst_q),
        .err_q    (wr_err),
        .dis_evt  (dis_evt)
    );

    assign flush    = sw_rst || dis_evt;
    assign push     = host_wr && en_q && !full;
    assign push_ent = '{last: host_eof, data: host_data};

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (push),
        .push_ent(push_ent),
        .pop     (pop),
        .head    (head),
        .count   (count),
        .empty   (empty),
        .full    (full)
    );

    txq_tx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .en_q       (en_q),
        .dis_evt    (dis_evt),
        .empty      (empty),
        .head       (head),
        .mac_ready  (mac_ready),
        .pop        (pop),
        .mac_valid  (mac_valid),
        .mac_data   (mac_data),
        .mac_sof    (mac_sof),
        .mac_eof    (mac_eof),
        .mac_bad_crc(mac_bad_crc)
    );

    // burst_q is held for software visibility of mode only; the request rule ignores it
    assign free_sp  = CW'(DEPTH) - count;
    assign host_req = en_q && (free_sp >= need_tbl[thr_q]);

    logic unused_burst;
    assign unused_burst = burst_q;

    AST_REQ_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_wr && !flush && !pop) |=> (count == $past(count) + CW'(1))); // R1
    AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_tx_en) |=> !host_req); // R5
endmodule

// File: tb/txq_host_ctrl_tb.sv
module txq_host_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       cfg_wr = 1'b0, cfg_tx_en = 1'b0, cfg_burst = 1'b0;
    logic [1:0] cfg_thr = 2'd0;
    logic       host_wr = 1'b0, host_eof = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_req, wr_err;
    logic       mac_ready = 1'b0;
    logic       mac_valid, mac_sof, mac_eof, mac_bad_crc;
    logic [7:0] mac_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    txq_host_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .cfg_wr(cfg_wr), .cfg_tx_en(cfg_tx_en), .cfg_thr(cfg_thr), .cfg_burst(cfg_burst),
        .host_wr(host_wr), .host_data(host_data), .host_eof(host_eof),
        .host_req(host_req), .wr_err(wr_err), .mac_ready(mac_ready),
        .mac_valid(mac_valid), .mac_data(mac_data), .mac_sof(mac_sof),
        .mac_eof(mac_eof), .mac_bad_crc(mac_bad_crc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic en, input logic [1:0] thr, input logic burst);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_tx_en = en; cfg_thr = thr; cfg_burst = burst;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_bytes(input int n, input int base, input bit eof_last);
        for (int i = 0; i < n; i++) begin
            host_wr = 1'b1; host_data = 8'(base + i);
            host_eof = eof_last && (i == n - 1);
            @(negedge clk);
        end
        host_wr = 1'b0; host_eof = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7", "host_req after reset", host_req, 0);
        chk("R7", "mac_valid after reset", mac_valid, 0);
        chk("R7", "wr_err after reset", wr_err, 0);
    endtask

    task automatic t_thresholds_and_order();
        int got;
        mac_ready = 1'b0;
        cfg(1'b1, 2'd3, 1'b0);
        chk("R1", "req thr3 empty", host_req, 1);
        wr_bytes(1, 0, 0);
        chk("R1", "req thr3 one byte", host_req, 0);
        cfg(1'b1, 2'd0, 1'b0);
        wr_bytes(55, 1, 0);
        chk("R1", "req thr0 at 8 free", host_req, 1);
        cfg(1'b1, 2'd0, 1'b1);
        chk("R2", "req burst at 8 free", host_req, 1);
        wr_bytes(1, 56, 0);
        chk("R2", "req burst at 7 free", host_req, 0);
        cfg(1'b1, 2'd0, 1'b0);
        chk("R1", "req thr0 at 7 free", host_req, 0);
        chk("R11", "offer data stalled", mac_data, 0);
        @(negedge clk);
        chk("R11", "offer held stalled", mac_valid, 1);
        chk("R11", "offer data held", mac_data, 0);
        wr_bytes(7, 57, 1);
        wr_bytes(1, 8'hAA, 0);
        chk("R10", "wr_err after full write", wr_err, 0);
        mac_ready = 1'b1;
        got = 0;
        for (int c = 0; c < 80; c++) begin
            if (mac_valid) begin
                chk("R4", "byte order", mac_data, got);
                chk("R4", "sof mark", mac_sof, (got == 0) ? 1 : 0);
                chk("R4", "eof mark", mac_eof, (got == 63) ? 1 : 0);
                got++;
            end
            @(negedge clk);
        end
        chk("R10", "bytes drained", got, 64);
        mac_ready = 1'b0;
    endtask

    task automatic t_abort_mid_frame();
        mac_ready = 1'b0;
        cfg(1'b1, 2'd3, 1'b0);
        wr_bytes(4, 8'h10, 0);
        mac_ready = 1'b1;
        chk("R4", "abort frame first byte", mac_data, 8'h10);
        @(negedge clk);
        chk("R4", "abort frame second byte", mac_data, 8'h11);
        @(negedge clk);
        mac_ready = 1'b0;
        cfg_wr = 1'b1; cfg_tx_en = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R6", "filler valid", mac_valid, 1);
        chk("R6", "filler data", mac_data, 0);
        chk("R6", "filler eof", mac_eof, 1);
        chk("R6", "filler bad crc", mac_bad_crc, 1);
        @(negedge clk);
        chk("R8", "bad crc held while stalled", mac_bad_crc, 1);
        mac_ready = 1'b1;
        @(negedge clk);
        chk("R8", "bad crc after accept", mac_bad_crc, 0);
        chk("R3", "quiet after abort", mac_valid, 0);
        @(negedge clk);
        chk("R3", "quiet while disabled", mac_valid, 0);
        mac_ready = 1'b0;
    endtask

    task automatic t_disable_between_frames();
        int extra = 0;
        cfg(1'b1, 2'd3, 1'b0);
        wr_bytes(2, 8'h20, 1);
        mac_ready = 1'b1;
        @(negedge clk); @(negedge clk);
        mac_ready = 1'b0;
        cfg(1'b0, 2'd3, 1'b0);
        mac_ready = 1'b1;
        for (int c = 0; c < 4; c++) begin
            if (mac_valid || mac_bad_crc) extra++;
            @(negedge clk);
        end
        chk("R6", "no filler between frames", extra, 0);
        mac_ready = 1'b0;
    endtask

    task automatic t_flush_reenable();
        cfg(1'b1, 2'd3, 1'b0);
        wr_bytes(3, 8'h30, 0);
        cfg(1'b0, 2'd3, 1'b0);
        chk("R3", "disabled no offer", mac_valid, 0);
        chk("R5", "no filler when no byte sent", mac_bad_crc, 0);
        cfg(1'b1, 2'd3, 1'b0);
        chk("R5", "all free after flush", host_req, 1);
        wr_bytes(1, 8'h5A, 1);
        chk("R5", "new frame data", mac_data, 8'h5A);
        chk("R5", "new frame sof", mac_sof, 1);
        chk("R4", "single byte eof", mac_eof, 1);
        mac_ready = 1'b1;
        @(negedge clk);
        mac_ready = 1'b0;
        chk("R4", "empty after drain", mac_valid, 0);
    endtask

    task automatic t_disabled_write_and_swrst();
        cfg(1'b0, 2'd0, 1'b0);
        wr_bytes(1, 8'h77, 1);
        chk("R9", "wr_err set", wr_err, 1);
        cfg(1'b1, 2'd3, 1'b0);
        chk("R9", "ignored write left queue empty", host_req, 1);
        chk("R9", "ignored write not sent", mac_valid, 0);
        chk("R9", "wr_err sticky", wr_err, 1);
        wr_bytes(2, 8'h40, 0);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        chk("R7", "sw reset clears err", wr_err, 0);
        chk("R7", "sw reset clears enable", host_req, 0);
        chk("R7", "sw reset no offer", mac_valid, 0);
        chk("R7", "sw reset no filler", mac_bad_crc, 0);
        cfg(1'b1, 2'd3, 1'b0);
        chk("R7", "sw reset emptied queue", host_req, 1);
        chk("R7", "sw reset queue no data", mac_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thresholds_and_order();
        t_abort_mid_frame();
        t_disable_between_frames();
        t_flush_reenable();
        t_disabled_write_and_swrst();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule